// File: doc/BRIEF.md
# Routed External Interrupt Controller

This block collects level-sensitive interrupt lines from external sources and steers each one to a chosen processor core. Within that core it steers the line to one of four interrupt pins. Steering happens in two stages. A per-source route byte picks the core. A per-group pin byte picks the pin for all 32 sources of the group. A source is marked in service at its core when it rises while enabled. A core's pin stays high while at least one in-service source is steered to that pin.

Software reaches the block through a 32-bit word register port. Each access carries the ID of the requesting core, and that ID selects which core's in-service word is read or cleared. Writes to an enable word or a route word take effect in the cycle the write is accepted. In that same cycle, sources that are already pending are delivered, withdrawn or moved, so the pin outputs have settled by the time the response returns. A small configuration pair controls how route bytes are decoded: a read-only capability word and a writable status word. A per-group spare word is stored and read back but has no effect.

Top module: `xirq_router`

## Requirements
- R1: After reset all pin outputs are low, the status word reads 0, the capability word (word address 0xF0) reads the FEATURES parameter, and every enable word reads 0.
- R2: Bit n of the enable word at word address 0x00+g controls source 32g+n. When a source's line rises and its enable bit is 1, the source becomes in service at its routed core and raises that core's mapped pin. When the enable bit is 0, the line raises nothing, although its raw level is still tracked.
- R3: Byte b of the pin word at 0x10+k maps group 4k+b, little-endian. The pin is the index of the lowest set bit among byte bits 3:0. A byte with none of those bits set selects pin 0. Pin output bit c*4+p is pin p of core c.
- R4: Byte j of the route word at 0x40+k routes source 4k+j, little-endian. The byte is decoded when it is written. If status bit 1 is clear, the core is the index of the lowest set bit among byte bits 3:0, or core 0 when none of those bits is set. If status bit 1 is set, the core is the byte value itself. Either way, a result of NUM_CORE or more selects core 0. A later change to status does not re-decode bytes already written. Route words read back the written bytes.
- R5: A pin output is high exactly while at least one in-service source is routed to that core and mapped to that pin. A falling source line removes the source from service.
- R6: When an enable bit goes from 0 to 1 while the source line is high, the source is delivered as if it had just risen. When an enable bit goes from 1 to 0, the source is withdrawn.
- R7: Writing the in-service word at 0x30+g clears, for the requesting core only, each bit written as 1 and leaves the other bits unchanged. A read returns the requesting core's word. A source cleared this way is not delivered again while its line stays high.
- R8: When a route write changes a source's decoded core while the source line is high, the source is withdrawn from the old core and then delivered to the new core, provided it is enabled.
- R9: A write to the capability word returns error and changes nothing. A write to the status word (0xF1) stores the written value ANDed with FEATURES. A nonzero status write while status bit 0 is set returns error and leaves status unchanged. A zero write is always accepted.
- R10: The spare word at 0x20+g stores and returns what was written. An unmapped address reads 0, ignores writes and returns no error.
- R11: Each accepted access returns exactly one response on the next cycle. The port is not ready in the response cycle, and all effects of the access are already visible at the pins in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_lvl_i | input | NUM_SRC | Level-sensitive source lines |
| bus_valid_i | input | 1 | Register access request |
| bus_ready_o | output | 1 | Port can accept a request this cycle |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_core_i | input | CW | ID of the requesting core |
| bus_rvalid_o | output | 1 | Response valid |
| bus_rdata_o | output | 32 | Read data (0 for writes) |
| bus_err_o | output | 1 | Access error |
| core_irq_o | output | NUM_CORE*4 | Pin outputs, bit c*4+p is pin p of core c |

## Verification
The bench builds the block with 64 sources, four cores and a capability word of 3, so the encoded-routing bit can be enabled. Two groups make it possible to give the groups different pin bytes at the same time. Four cores let each route decode land on a distinct core. With the encoded-routing bit available, the bench can drive an encoded byte above the core count and confirm that a byte written under one decode mode keeps its core after the mode changes.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int GRP_W  = 32;
    localparam int PIN_N  = 4;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] ADR_FEAT = 8'hF0;
    localparam logic [ADDR_W-1:0] ADR_STAT = 8'hF1;

    localparam int ST_ON  = 0;
    localparam int ST_ENC = 1;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_EN,
        RS_PIN,
        RS_SPARE,
        RS_ISR,
        RS_ROUTE,
        RS_FEAT,
        RS_STAT
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [5:0] idx;
    } reg_hit_t;

    typedef struct packed {
        logic        vld;
        logic [31:0] data;
        logic        err;
    } bus_rsp_t;

    // index of lowest set bit among bits 3:0, zero when none
    function automatic logic [1:0] low_set_idx(input logic [7:0] b);
        if (b[0]) return 2'd0;
        if (b[1]) return 2'd1;
        if (b[2]) return 2'd2;
        if (b[3]) return 2'd3;
        return 2'd0;
    endfunction

    function automatic reg_hit_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int ng, input int npw,
                                             input int nrw);
        reg_hit_t h;
        h.sel = RS_NONE;
        h.idx = a[5:0];
        if (a == ADR_FEAT) begin
            h.sel = RS_FEAT;
        end else if (a == ADR_STAT) begin
            h.sel = RS_STAT;
        end else if (a[7:6] == 2'b01) begin
            if (int'(a[5:0]) < nrw) h.sel = RS_ROUTE;
        end else if (a[7:6] == 2'b00) begin
            h.idx = {2'b00, a[3:0]};
            case (a[5:4])
                2'd0:    if (int'(a[3:0]) < ng)  h.sel = RS_EN;
                2'd1:    if (int'(a[3:0]) < npw) h.sel = RS_PIN;
                2'd2:    if (int'(a[3:0]) < ng)  h.sel = RS_SPARE;
                default: if (int'(a[3:0]) < ng)  h.sel = RS_ISR;
            endcase
        end
        return h;
    endfunction

endpackage

// File: rtl/xirq_regs.sv
module xirq_regs
    import xirq_pkg::*;
#(
    parameter int          NUM_SRC  = 64,
    parameter int          NUM_CORE = 4,
    parameter logic [31:0] FEATURES = 32'h0000_0003,
    localparam int         CW       = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1,
    localparam int         NG       = NUM_SRC / GRP_W
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   wr_go_i,
    input  reg_hit_t               hit_i,
    input  logic [31:0]            wdata_i,
    output logic [NUM_SRC-1:0]     en_cur_o,
    output logic [NUM_SRC-1:0]     en_nxt_o,
    output logic [NUM_SRC*CW-1:0]  route_cur_o,
    output logic [NUM_SRC*CW-1:0]  route_nxt_o,
    output logic [NG*2-1:0]        grp_pin_o,
    output logic [31:0]            rdata_o,
    output logic                   wr_err_o
);

    localparam int NPW = (NG + 3) / 4;
    localparam int NRW = NUM_SRC / 4;

    logic [31:0]   en_q    [NG];
    logic [31:0]   spare_q [NG];
    logic [31:0]   pin_q   [NPW];
    logic [7:0]    rbyte_q [NUM_SRC];
    logic [CW-1:0] rcore_q [NUM_SRC];
    logic [31:0]   stat_q;
    logic          stat_err;

    function automatic logic [CW-1:0] dec_core(input logic [7:0] b, input logic enc);
        int v;
        v = enc ? int'(b) : int'(low_set_idx(b));
        if (v >= NUM_CORE) v = 0;
        return v[CW-1:0];
    endfunction

    assign stat_err = wr_go_i && (hit_i.sel == RS_STAT) && stat_q[ST_ON] && (wdata_i != '0);
    assign wr_err_o = (wr_go_i && (hit_i.sel == RS_FEAT)) || stat_err;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stat_q <= '0;
        end else if (wr_go_i && (hit_i.sel == RS_STAT) && !stat_err) begin
            stat_q <= wdata_i & FEATURES;
        end
    end

    for (genvar g = 0; g < NG; g++) begin : g_grp
        logic en_wr;
        logic sp_wr;
        assign en_wr = wr_go_i && (hit_i.sel == RS_EN) && (hit_i.idx == 6'(g));
        assign sp_wr = wr_go_i && (hit_i.sel == RS_SPARE) && (hit_i.idx == 6'(g));
        assign en_cur_o[g*GRP_W +: GRP_W] = en_q[g];
        assign en_nxt_o[g*GRP_W +: GRP_W] = en_wr ? wdata_i : en_q[g];
        assign grp_pin_o[g*2 +: 2] = low_set_idx(pin_q[g/4][(g%4)*8 +: 8]);

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                en_q[g]    <= '0;
                spare_q[g] <= '0;
            end else begin
                en_q[g] <= en_nxt_o[g*GRP_W +: GRP_W];
                if (sp_wr) spare_q[g] <= wdata_i;
            end
        end
    end

    for (genvar k = 0; k < NPW; k++) begin : g_pinw
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                pin_q[k] <= '0;
            end else if (wr_go_i && (hit_i.sel == RS_PIN) && (hit_i.idx == 6'(k))) begin
                pin_q[k] <= wdata_i;
            end
        end
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic       rt_wr;
        logic [7:0] byte_w;
        assign rt_wr  = wr_go_i && (hit_i.sel == RS_ROUTE) && (hit_i.idx == 6'(s/4));
        assign byte_w = wdata_i[(s%4)*8 +: 8];
        assign route_cur_o[s*CW +: CW] = rcore_q[s];
        assign route_nxt_o[s*CW +: CW] = rt_wr ? dec_core(byte_w, stat_q[ST_ENC]) : rcore_q[s];

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                rbyte_q[s] <= '0;
                rcore_q[s] <= '0;
            end else begin
                rcore_q[s] <= route_nxt_o[s*CW +: CW];
                if (rt_wr) rbyte_q[s] <= byte_w;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        case (hit_i.sel)
            RS_EN: begin
                for (int g = 0; g < NG; g++)
                    if (hit_i.idx == 6'(g)) rdata_o = en_q[g];
            end
            RS_SPARE: begin
                for (int g = 0; g < NG; g++)
                    if (hit_i.idx == 6'(g)) rdata_o = spare_q[g];
            end
            RS_PIN: begin
                for (int k = 0; k < NPW; k++)
                    if (hit_i.idx == 6'(k)) rdata_o = pin_q[k];
            end
            RS_ROUTE: begin
                for (int k = 0; k < NRW; k++)
                    if (hit_i.idx == 6'(k))
                        rdata_o = {rbyte_q[4*k+3], rbyte_q[4*k+2], rbyte_q[4*k+1], rbyte_q[4*k]};
            end
            RS_FEAT: rdata_o = FEATURES;
            RS_STAT: rdata_o = stat_q;
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/xirq_isr.sv
module xirq_isr
    import xirq_pkg::*;
#(
    parameter int  NUM_SRC  = 64,
    parameter int  NUM_CORE = 4,
    localparam int CW       = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1,
    localparam int NG       = NUM_SRC / GRP_W
) (
    input  logic                          clk_i,
    input  logic                          rst_i,
    input  logic [NUM_SRC-1:0]            raw_q_i,
    input  logic [NUM_SRC-1:0]            src_i,
    input  logic [NUM_SRC-1:0]            en_cur_i,
    input  logic [NUM_SRC-1:0]            en_nxt_i,
    input  logic [NUM_SRC*CW-1:0]         route_cur_i,
    input  logic [NUM_SRC*CW-1:0]         route_nxt_i,
    input  logic                          clr_go_i,
    input  logic [CW-1:0]                 clr_core_i,
    input  logic [5:0]                    clr_grp_i,
    input  logic [31:0]                   clr_mask_i,
    output logic [NUM_CORE*NUM_SRC-1:0]   isr_o
);

    logic [NUM_CORE*NUM_SRC-1:0] isr_q;
    logic [NUM_CORE*NUM_SRC-1:0] isr_d;
    logic [NUM_SRC-1:0]          clr_vec;

    always_comb begin
        clr_vec = '0;
        for (int g = 0; g < NG; g++)
            if (clr_go_i && (clr_grp_i == 6'(g))) clr_vec[g*GRP_W +: GRP_W] = clr_mask_i;
    end

    // register-write effects first, then line edges judged with the new settings
    always_comb begin
        for (int c = 0; c < NUM_CORE; c++) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                logic          v;
                logic [CW-1:0] rc;
                logic [CW-1:0] rn;
                rc = route_cur_i[s*CW +: CW];
                rn = route_nxt_i[s*CW +: CW];
                v  = isr_q[c*NUM_SRC + s];
                if (en_cur_i[s] && !en_nxt_i[s]) v = 1'b0;
                if (!en_cur_i[s] && en_nxt_i[s] && raw_q_i[s] && (rn == CW'(c))) v = 1'b1;
                if (raw_q_i[s] && (rn != rc)) begin
                    if (rc == CW'(c)) v = 1'b0;
                    if ((rn == CW'(c)) && en_nxt_i[s]) v = 1'b1;
                end
                if (clr_vec[s] && (clr_core_i == CW'(c))) v = 1'b0;
                if (!src_i[s] && raw_q_i[s]) v = 1'b0;
                if (src_i[s] && !raw_q_i[s] && en_nxt_i[s] && (rn == CW'(c))) v = 1'b1;
                isr_d[c*NUM_SRC + s] = v;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) isr_q <= '0;
        else       isr_q <= isr_d;
    end

    assign isr_o = isr_q;

endmodule

// File: rtl/xirq_pinmerge.sv
module xirq_pinmerge
    import xirq_pkg::*;
#(
    parameter int  NUM_SRC  = 64,
    parameter int  NUM_CORE = 4,
    localparam int NG       = NUM_SRC / GRP_W
) (
    input  logic [NUM_CORE*NUM_SRC-1:0] isr_i,
    input  logic [NG*2-1:0]             grp_pin_i,
    output logic [NUM_CORE*PIN_N-1:0]   irq_o
);

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        for (genvar p = 0; p < PIN_N; p++) begin : g_pin
            logic acc;
            always_comb begin
                acc = 1'b0;
                for (int s = 0; s < NUM_SRC; s++)
                    if ((grp_pin_i[(s/GRP_W)*2 +: 2] == 2'(p)) && isr_i[c*NUM_SRC + s]) acc = 1'b1;
            end
            assign irq_o[c*PIN_N + p] = acc;
        end
    end

endmodule

// File: rtl/xirq_router.sv
module xirq_router
    import xirq_pkg::*;
#(
    parameter int          NUM_SRC  = 64,
    parameter int          NUM_CORE = 4,
    parameter logic [31:0] FEATURES = 32'h0000_0003,
    localparam int         CW       = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic [NUM_SRC-1:0]        src_lvl_i,
    input  logic                      bus_valid_i,
    output logic                      bus_ready_o,
    input  logic                      bus_we_i,
    input  logic [7:0]                bus_addr_i,
    input  logic [31:0]               bus_wdata_i,
    input  logic [CW-1:0]             bus_core_i,
    output logic                      bus_rvalid_o,
    output logic [31:0]               bus_rdata_o,
    output logic                      bus_err_o,
    output logic [NUM_CORE*PIN_N-1:0] core_irq_o
);

    localparam int NG  = NUM_SRC / GRP_W;
    localparam int NPW = (NG + 3) / 4;
    localparam int NRW = NUM_SRC / 4;

    logic [NUM_SRC-1:0]          raw_q;
    logic                        accept;
    logic                        wr_go;
    logic                        core_ok;
    logic                        clr_go;
    reg_hit_t                    hit;
    bus_rsp_t                    rsp_q;
    logic [NUM_SRC-1:0]          en_cur, en_nxt;
    logic [NUM_SRC*CW-1:0]       route_cur, route_nxt;
    logic [NG*2-1:0]             grp_pin;
    logic [31:0]                 reg_rdata;
    logic                        wr_err;
    logic [NUM_CORE*NUM_SRC-1:0] isr_flat;
    logic [31:0]                 isr_word;
    logic [31:0]                 rd_mux;

    assign bus_ready_o = !rsp_q.vld;
    assign accept      = bus_valid_i && bus_ready_o;
    assign wr_go       = accept && bus_we_i;
    assign hit         = decode_addr(bus_addr_i, NG, NPW, NRW);
    assign core_ok     = int'(bus_core_i) < NUM_CORE;
    assign clr_go      = wr_go && (hit.sel == RS_ISR) && core_ok;

    always_ff @(posedge clk_i) begin
        if (rst_i) raw_q <= '0;
        else       raw_q <= src_lvl_i;
    end

    xirq_regs #(
        .NUM_SRC  (NUM_SRC),
        .NUM_CORE (NUM_CORE),
        .FEATURES (FEATURES)
    ) regs_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .wr_go_i     (wr_go),
        .hit_i       (hit),
        .wdata_i     (bus_wdata_i),
        .en_cur_o    (en_cur),
        .en_nxt_o    (en_nxt),
        .route_cur_o (route_cur),
        .route_nxt_o (route_nxt),
        .grp_pin_o   (grp_pin),
        .rdata_o     (reg_rdata),
        .wr_err_o    (wr_err)
    );

    xirq_isr #(
        .NUM_SRC  (NUM_SRC),
        .NUM_CORE (NUM_CORE)
    ) isr_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .raw_q_i     (raw_q),
        .src_i       (src_lvl_i),
        .en_cur_i    (en_cur),
        .en_nxt_i    (en_nxt),
        .route_cur_i (route_cur),
        .route_nxt_i (route_nxt),
        .clr_go_i    (clr_go),
        .clr_core_i  (bus_core_i),
        .clr_grp_i   (hit.idx),
        .clr_mask_i  (bus_wdata_i),
        .isr_o       (isr_flat)
    );

    xirq_pinmerge #(
        .NUM_SRC  (NUM_SRC),
        .NUM_CORE (NUM_CORE)
    ) merge_i (
        .isr_i     (isr_flat),
        .grp_pin_i (grp_pin),
        .irq_o     (core_irq_o)
    );

    always_comb begin
        isr_word = '0;
        for (int c = 0; c < NUM_CORE; c++)
            for (int g = 0; g < NG; g++)
                if ((bus_core_i == CW'(c)) && (hit.idx == 6'(g)))
                    isr_word = isr_flat[c*NUM_SRC + g*GRP_W +: GRP_W];
    end

    assign rd_mux = (hit.sel == RS_ISR) ? (core_ok ? isr_word : '0) : reg_rdata;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rsp_q <= '0;
        end else begin
            rsp_q.vld <= accept;
            if (accept) begin
                rsp_q.data <= bus_we_i ? 32'h0 : rd_mux;
                rsp_q.err  <= wr_err;
            end
        end
    end

    assign bus_rvalid_o = rsp_q.vld;
    assign bus_rdata_o  = rsp_q.data;
    assign bus_err_o    = rsp_q.err;

endmodule

// File: rtl/xirq_router_chk.sv
module xirq_router_chk #(
    parameter int  NUM_SRC  = 64,
    parameter int  NUM_CORE = 4,
    localparam int CW       = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
    input logic                    clk_i,
    input logic                    rst_i,
    input logic [NUM_SRC-1:0]      src_lvl_i,
    input logic                    bus_valid_i,
    input logic                    bus_ready_o,
    input logic                    bus_we_i,
    input logic [7:0]              bus_addr_i,
    input logic                    bus_rvalid_o,
    input logic                    bus_err_o,
    input logic [NUM_CORE*4-1:0]   core_irq_o
);

    logic acc;
    assign acc = bus_valid_i && bus_ready_o;

    AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk_i) disable iff (rst_i)
        acc |=> bus_rvalid_o); // R11
    AST_READY_LOW_ON_RSP: assert property (@(posedge clk_i) disable iff (rst_i)
        bus_rvalid_o |-> !bus_ready_o); // R11
    AST_RSP_NEEDS_ACCEPT: assert property (@(posedge clk_i) disable iff (rst_i)
        bus_rvalid_o |-> $past(acc)); // R11
    AST_FEAT_WRITE_REJECT: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc && bus_we_i && (bus_addr_i == 8'hF0)) |=> bus_err_o); // R9
    AST_UNMAPPED_NO_ERR: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc && (bus_addr_i == 8'hE0)) |=> !bus_err_o); // R10
    AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(src_lvl_i) == '0) |-> (core_irq_o == '0)); // R5

endmodule

bind xirq_router xirq_router_chk #(
    .NUM_SRC  (NUM_SRC),
    .NUM_CORE (NUM_CORE)
) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .src_lvl_i    (src_lvl_i),
    .bus_valid_i  (bus_valid_i),
    .bus_ready_o  (bus_ready_o),
    .bus_we_i     (bus_we_i),
    .bus_addr_i   (bus_addr_i),
    .bus_rvalid_o (bus_rvalid_o),
    .bus_err_o    (bus_err_o),
    .core_irq_o   (core_irq_o)
);

// File: tb/xirq_router_tb_top.sv
module xirq_router_tb_top;

    localparam int NSRC = 64;
    localparam int NCOR = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src = '0;
    logic            valid = 1'b0;
    logic            ready;
    logic            we = 1'b0;
    logic [7:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [1:0]      core = '0;
    logic            rvalid;
    logic [31:0]     rdata;
    logic            err;
    logic [15:0]     irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] data;
        logic        err;
        string       tag;
    } exp_t;
    exp_t expq[$];

    always #2 clk = ~clk;

    xirq_router #(.NUM_SRC(NSRC), .NUM_CORE(NCOR), .FEATURES(32'h3)) dut_i (
        .clk_i(clk), .rst_i(rst), .src_lvl_i(src),
        .bus_valid_i(valid), .bus_ready_o(ready), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_core_i(core),
        .bus_rvalid_o(rvalid), .bus_rdata_o(rdata), .bus_err_o(err),
        .core_irq_o(irq)
    );

    task automatic chk32(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard entries as responses appear
    always @(negedge clk) begin
        if (!rst && rvalid) begin
            if (expq.size() == 0) begin
                chk32(32'h1, 32'h0, "R11 response without request");
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk32(rdata, e.data, {e.tag, " data"});
                chk32({31'h0, err}, {31'h0, e.err}, {e.tag, " err"});
                chk32({31'h0, ready}, 32'h0, "R11 ready low in response cycle");
            end
        end
    end

    task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic [1:0] cr, input logic [31:0] ed, input logic ee,
                       input string tag);
        exp_t e;
        while (!ready) @(negedge clk);
        e.data = ed; e.err = ee; e.tag = tag;
        expq.push_back(e);
        valid = 1'b1; we = w; addr = a; wdata = d; core = cr;
        @(posedge clk);
        @(negedge clk);
        valid = 1'b0; we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        bus(1'b1, a, d, 2'd0, 32'h0, 1'b0, tag);
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] cr, input logic [31:0] ed, input string tag);
        bus(1'b0, a, 32'h0, cr, ed, 1'b0, tag);
    endtask

    task automatic line(input int i, input logic v);
        src[i] = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pins(input logic [15:0] exp, input string tag);
        chk32({16'h0, irq}, {16'h0, exp}, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        pins(16'h0, "R1 pins low after reset");
        rd(8'hF1, 0, 32'h0, "R1 status zero");
        rd(8'hF0, 0, 32'h3, "R1 capability word");
        rd(8'h00, 0, 32'h0, "R1 enable word zero");

        // R10 spare words and unmapped space
        wr(8'h20, 32'hA5A5_0001, "R10 spare write");
        rd(8'h20, 0, 32'hA5A5_0001, "R10 spare readback g0");
        wr(8'h21, 32'h0000_FF00, "R10 spare write g1");
        rd(8'h21, 0, 32'h0000_FF00, "R10 spare readback g1");
        wr(8'hE0, 32'hFFFF_FFFF, "R10 unmapped write no error");
        rd(8'hE0, 0, 32'h0, "R10 unmapped reads zero");
        rd(8'h50, 0, 32'h0, "R10 route space beyond sources reads zero");

        // R2 enable gating, default routes core 0, pin 0
        wr(8'h00, 32'h1, "R2 enable source 0");
        line(1, 1'b1);
        pins(16'h0, "R2 disabled source raises nothing");
        rd(8'h30, 0, 32'h0, "R2 disabled source not in service");
        line(1, 1'b0);
        line(0, 1'b1);
        pins(16'h0001, "R2 enabled source raises core0 pin0");
        rd(8'h30, 0, 32'h1, "R2 in-service bit 0 at core 0");

        // R5 pin holds until last in-service source leaves
        wr(8'h00, 32'h5, "R5 enable sources 0 and 2");
        line(2, 1'b1);
        rd(8'h30, 0, 32'h5, "R5 two sources in service");
        line(0, 1'b0);
        pins(16'h0001, "R5 pin held by remaining source");
        line(2, 1'b0);
        pins(16'h0, "R5 pin drops after last source");

        // R3 group pin maps
        wr(8'h10, 32'h0000_0A04, "R3 pin word");
        wr(8'h00, 32'h1, "R3 enable g0");
        wr(8'h01, 32'h8, "R3 enable source 35");
        line(0, 1'b1);
        pins(16'h0004, "R3 group0 byte 0x04 to pin2");
        line(35, 1'b1);
        pins(16'h0006, "R3 group1 byte 0x0A to pin1");
        line(0, 1'b0);
        line(35, 1'b0);
        pins(16'h0, "R3 both released");
        wr(8'h10, 32'h0000_0A30, "R3 pin byte without low bits");
        line(0, 1'b1);
        pins(16'h0001, "R3 byte 0x30 selects pin0");
        line(0, 1'b0);

        // R4 route decode, plain mode
        wr(8'h40, 32'h0010_0608, "R4 plain route word");
        wr(8'h00, 32'hF, "R4 enable 0..3");
        line(0, 1'b1); pins(16'h1000, "R4 byte 0x08 to core3"); line(0, 1'b0);
        line(1, 1'b1); pins(16'h0010, "R4 byte 0x06 to core1"); line(1, 1'b0);
        line(2, 1'b1); pins(16'h0001, "R4 byte 0x10 to core0"); line(2, 1'b0);
        // R4 encoded mode
        wr(8'hF1, 32'h2, "R4 set encoded routing");
        rd(8'hF1, 0, 32'h2, "R4 status readback");
        wr(8'h40, 32'h0103_0702, "R4 encoded route word");
        line(0, 1'b1); pins(16'h0100, "R4 encoded 2 to core2"); line(0, 1'b0);
        line(1, 1'b1); pins(16'h0001, "R4 encoded 7 beyond cores to core0"); line(1, 1'b0);
        line(2, 1'b1); pins(16'h1000, "R4 encoded 3 to core3"); line(2, 1'b0);
        wr(8'hF1, 32'h0, "R4 back to plain mode");
        line(3, 1'b1); pins(16'h0010, "R4 decode fixed at write time"); line(3, 1'b0);

        // R8 route move while pending
        line(0, 1'b1);
        pins(16'h0100, "R8 pending at core2");
        wr(8'h40, 32'h0108_0702, "R8 reroute source 0 to core1");
        pins(16'h0010, "R8 moved to core1");
        rd(8'h30, 2, 32'h0, "R8 old core cleared");
        rd(8'h30, 1, 32'h1, "R8 new core in service");
        rd(8'h40, 0, 32'h0108_0702, "R4 route bytes read back");
        line(0, 1'b0);
        pins(16'h0, "R8 released");

        // R6 enable edges on a pending source
        line(1, 1'b1);
        pins(16'h0001, "R6 source 1 at core0");
        wr(8'h00, 32'hD, "R6 disable source 1");
        pins(16'h0, "R6 withdrawn on disable");
        rd(8'h30, 0, 32'h0, "R6 in-service cleared on disable");
        wr(8'h00, 32'hF, "R6 re-enable source 1");
        pins(16'h0001, "R6 delivered on enable");
        line(1, 1'b0);

        // R7 write-one-to-clear per requesting core
        src[0] = 1'b1; src[2] = 1'b1;
        @(posedge clk); @(negedge clk);
        pins(16'h1010, "R7 core1 and core3 raised");
        bus(1'b1, 8'h30, 32'h0, 2'd1, 32'h0, 1'b0, "R7 zero mask");
        pins(16'h1010, "R7 zero mask clears nothing");
        bus(1'b1, 8'h30, 32'h1, 2'd3, 32'h0, 1'b0, "R7 other core mask");
        pins(16'h1010, "R7 other core unaffected");
        bus(1'b1, 8'h30, 32'h1, 2'd1, 32'h0, 1'b0, "R7 clear at core1");
        pins(16'h1000, "R7 core1 pin dropped");
        rd(8'h30, 1, 32'h0, "R7 core1 word");
        rd(8'h30, 3, 32'h4, "R7 core3 word");
        repeat (3) @(negedge clk);
        pins(16'h1000, "R7 no redelivery while line high");
        src[0] = 1'b0; src[2] = 1'b0;
        @(posedge clk); @(negedge clk);
        pins(16'h0, "R7 released");

        // R9 configuration pair
        bus(1'b1, 8'hF0, 32'h0, 2'd0, 32'h0, 1'b1, "R9 capability write error");
        rd(8'hF0, 0, 32'h3, "R9 capability unchanged");
        wr(8'hF1, 32'h7, "R9 status write masked");
        rd(8'hF1, 0, 32'h3, "R9 status equals value AND capability");
        bus(1'b1, 8'hF1, 32'h2, 2'd0, 32'h0, 1'b1, "R9 nonzero write while on");
        rd(8'hF1, 0, 32'h3, "R9 status unchanged after error");
        wr(8'hF1, 32'h0, "R9 zero write accepted");
        rd(8'hF1, 0, 32'h0, "R9 status cleared");

        repeat (4) @(negedge clk);
        chk32(expq.size(), 0, "R11 every access answered");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule